// File: doc/BRIEF.md
# Host Microprocessor Bus Port with Automatic Timing Selection

This block lets a host processor reach the configuration registers and the two switching memories (connection memory and data memory) of a time-slot switch. A mode pin picks between two kinds of bus. When the pin is low, the bus is non-multiplexed, with its own address lines. When the pin is high, the bus is multiplexed and the low data byte carries the address during an address-strobe phase. On a multiplexed bus the block works out which timing the host uses by looking at the data-strobe/read line at the moment the address strobe rises, so no configuration step is needed.

The address space has two halves. The top address bit selects a small register page or a memory window. The memory window is paged by a control register: a memory-select bit chooses the memory, and a stream field forms the upper part of the memory address. The window is limited to 32, 64 or 128 locations by a rate field in the mode register. Every access is acknowledged a fixed number of clocks after it starts, and the acknowledge is released when the access ends. Writes to read-only locations are acknowledged and then dropped. The memories sit outside the block, behind a simple request/write-enable port.

Top module: `host_bus_if`

## Requirements
- R1: With `im_i` low, the address comes from `addr_i`. A transfer is active while `cs_n_i` is low and `ds_rd_i` is low, and `rw_i` high means read.
- R2: With `im_i` high, a rising edge of `as_i` samples `ds_rd_i`. A low level selects timing A: `ds_rd_i` is an active-high strobe and `rw_i` high means read. A high level selects timing B: `ds_rd_i` is an active-low read strobe and `rw_i` is an active-low write strobe. The choice holds until the next rising edge of `as_i`.
- R3: With `im_i` high, the address is taken from `dat_i[7:0]` on every clock edge where `as_i` is high, and it is held after `as_i` falls.
- R4: `ack_o` goes high on the second clock edge at which chip select and a strobe are both sampled active. It stays high while they remain active, and it clears on the first edge at which either is inactive. Each transfer performs exactly one register or memory write.
- R5: Address bit 7 low selects the register page. Offset 0 is the mode register (`mode_reg_o`), 1 is the control register, 2 is the alignment value (`align_i`) and 3 is the offset register (`offset_reg_o`). Any other offset reads 0 and ignores writes.
- R6: Mode register bits [1:0] give the window size: 0 gives 32 locations, 1 gives 64, and 2 or 3 give 128. A memory offset (address bits 6..0) at or above that size raises no memory request, reads 0 and drops writes.
- R7: Control register bits [4:0] are the stream field and bit 5 is the memory select (1 = data memory). The control register reads back only these six bits. `mem_addr_o` is {stream, offset} and `mem_sel_o` follows bit 5.
- R8: The data memory and the alignment location are read-only. Writes to them are acknowledged, but they never pulse `mem_we_o` and never change what is read back.
- R9: After synchronous reset, the mode, control and offset registers are zero and `ack_o`, `dat_oe_o` and `mem_req_o` are low.
- R10: On a read, `dat_o` holds the value of the addressed location, captured on the edge where `ack_o` rises. `dat_oe_o` is high while `ack_o` is high and the transfer is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| im_i | input | 1 | Bus kind: 0 non-multiplexed, 1 multiplexed |
| cs_n_i | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe / latch enable |
| ds_rd_i | input | 1 | Data strobe or read strobe, polarity per timing |
| rw_i | input | 1 | Read/write level or write strobe, per timing |
| addr_i | input | 8 | Address on the non-multiplexed bus |
| dat_i | input | 16 | Write data; low byte carries the address when multiplexed |
| dat_o | output | 16 | Read data |
| dat_oe_o | output | 1 | Read data drive enable |
| ack_o | output | 1 | Transfer acknowledge |
| mem_req_o | output | 1 | Memory window access in range |
| mem_we_o | output | 1 | One-clock memory write pulse |
| mem_sel_o | output | 1 | 0 connection memory, 1 data memory |
| mem_addr_o | output | 12 | {stream, offset} memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, combinational from address |
| align_i | input | 16 | Read-only alignment value |
| mode_reg_o | output | 16 | Mode register contents |
| offset_reg_o | output | 16 | Offset register contents |

## Verification
Once chip select and a strobe are applied, the acknowledge is due on the second following clock edge, and the read data and the single write pulse come on that same edge. The acknowledge must clear one edge after the strobe or the chip select is withdrawn. The bench drives at the falling edge and samples at the falling edge after each of these rising edges, so every comparison falls half a period after the register that produces the value. Memory write pulses are counted at each rising edge and compared per transfer. Read-back values are compared with a bench model of registers and memory that follows R5 to R8 across all three bus timings.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;

    typedef enum logic [1:0] {
        BUS_PLAIN    = 2'd0,
        BUS_MUX_DS   = 2'd1,
        BUS_MUX_RDWR = 2'd2
    } bus_kind_e;

    typedef struct packed {
        logic active;
        logic read;
    } bus_req_t;

    localparam int REG_MODE  = 0;
    localparam int REG_CTRL  = 1;
    localparam int REG_ALIGN = 2;
    localparam int REG_OFFS  = 3;

    function automatic int unsigned loc_count(input logic [1:0] rate);
        case (rate)
            2'd0:    return 32;
            2'd1:    return 64;
            default: return 128;
        endcase
    endfunction

endpackage

// File: rtl/hbi_mode_detect.sv
module hbi_mode_detect
    import host_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              im_i,
    input  logic              as_i,
    input  logic              ds_rd_i,
    input  logic [ADDR_W-1:0] dat_lo_i,
    input  logic [ADDR_W-1:0] addr_i,
    output bus_kind_e         kind_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic              as_q;
    bus_kind_e         mux_kind_q;
    logic [ADDR_W-1:0] mux_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_q       <= 1'b0;
            mux_kind_q <= BUS_MUX_DS;
            mux_addr_q <= '0;
        end else begin
            as_q <= as_i;
            if (im_i && as_i && !as_q)
                mux_kind_q <= ds_rd_i ? BUS_MUX_RDWR : BUS_MUX_DS;
            if (im_i && as_i)
                mux_addr_q <= dat_lo_i;
        end
    end

    assign kind_o = im_i ? mux_kind_q : BUS_PLAIN;
    assign addr_o = im_i ? mux_addr_q : addr_i;

endmodule

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode
    import host_bus_pkg::*;
(
    input  bus_kind_e kind_i,
    input  logic      cs_n_i,
    input  logic      ds_rd_i,
    input  logic      rw_i,
    output bus_req_t  req_o
);
    logic strobe;
    logic rd;

    always_comb begin
        case (kind_i)
            BUS_MUX_DS: begin
                strobe = ds_rd_i;
                rd     = rw_i;
            end
            BUS_MUX_RDWR: begin
                strobe = !ds_rd_i || !rw_i;
                rd     = !ds_rd_i;
            end
            default: begin
                strobe = !ds_rd_i;
                rd     = rw_i;
            end
        endcase
        req_o.active = !cs_n_i && strobe;
        req_o.read   = rd;
    end

endmodule

// File: rtl/hbi_ack_timer.sv
module hbi_ack_timer #(
    parameter int ACK_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic fire_o,
    output logic ack_o
);
    localparam int CW = $clog2(ACK_DLY + 1);

    logic [CW-1:0] cnt_q;
    logic          ack_q;

    assign fire_o = active_i && (cnt_q == CW'(ACK_DLY - 1));
    assign ack_o  = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
        end else if (!active_i) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
        end else begin
            if (cnt_q != CW'(ACK_DLY))
                cnt_q <= cnt_q + 1'b1;
            if (fire_o)
                ack_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile
    import host_bus_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 8,
    parameter int STREAM_W = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       active_i,
    input  logic                       read_i,
    input  logic                       fire_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [DATA_W-1:0]          align_i,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic                       mem_sel_o,
    output logic [STREAM_W+ADDR_W-2:0] mem_addr_o,
    output logic [DATA_W-1:0]          mem_wdata_o,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [DATA_W-1:0]          mode_o,
    output logic [DATA_W-1:0]          offs_o
);
    localparam int OFF_W   = ADDR_W - 1;
    localparam int SEL_BIT = STREAM_W;

    logic [DATA_W-1:0]   mode_q;
    logic [STREAM_W:0]   ctrl_q;
    logic [DATA_W-1:0]   offs_q;
    logic                is_mem;
    logic [OFF_W-1:0]    off;
    logic                in_range;
    logic                reg_wr;

    assign is_mem   = addr_i[ADDR_W-1];
    assign off      = addr_i[OFF_W-1:0];
    assign in_range = int'(off) < loc_count(mode_q[1:0]);
    assign reg_wr   = fire_i && !read_i && !is_mem;

    assign mem_sel_o   = ctrl_q[SEL_BIT];
    assign mem_addr_o  = {ctrl_q[STREAM_W-1:0], off};
    assign mem_wdata_o = wdata_i;
    assign mem_req_o   = active_i && is_mem && in_range;
    assign mem_we_o    = fire_i && !read_i && is_mem && in_range && !ctrl_q[SEL_BIT];

    assign mode_o = mode_q;
    assign offs_o = offs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctrl_q <= '0;
            offs_q <= '0;
        end else if (reg_wr) begin
            case (off)
                OFF_W'(REG_MODE): mode_q <= wdata_i;
                OFF_W'(REG_CTRL): ctrl_q <= wdata_i[STREAM_W:0];
                OFF_W'(REG_OFFS): offs_q <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (is_mem) begin
            if (in_range)
                rdata_o = mem_rdata_i;
        end else begin
            case (off)
                OFF_W'(REG_MODE):  rdata_o = mode_q;
                OFF_W'(REG_CTRL):  rdata_o = DATA_W'(ctrl_q);
                OFF_W'(REG_ALIGN): rdata_o = align_i;
                OFF_W'(REG_OFFS):  rdata_o = offs_q;
                default:           rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
    import host_bus_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 8,
    parameter int STREAM_W = 5,
    parameter int ACK_DLY  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       im_i,
    input  logic                       cs_n_i,
    input  logic                       as_i,
    input  logic                       ds_rd_i,
    input  logic                       rw_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          dat_i,
    output logic [DATA_W-1:0]          dat_o,
    output logic                       dat_oe_o,
    output logic                       ack_o,
    output logic                       mem_req_o,
    output logic                       mem_we_o,
    output logic                       mem_sel_o,
    output logic [STREAM_W+ADDR_W-2:0] mem_addr_o,
    output logic [DATA_W-1:0]          mem_wdata_o,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    input  logic [DATA_W-1:0]          align_i,
    output logic [DATA_W-1:0]          mode_reg_o,
    output logic [DATA_W-1:0]          offset_reg_o
);
    bus_kind_e         kind_s;
    logic [ADDR_W-1:0] addr_s;
    bus_req_t          req_s;
    logic              fire_s;
    logic [DATA_W-1:0] rdata_s;
    logic [DATA_W-1:0] dat_q;

    hbi_mode_detect #(.ADDR_W(ADDR_W)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .im_i     (im_i),
        .as_i     (as_i),
        .ds_rd_i  (ds_rd_i),
        .dat_lo_i (dat_i[ADDR_W-1:0]),
        .addr_i   (addr_i),
        .kind_o   (kind_s),
        .addr_o   (addr_s)
    );

    hbi_strobe_decode u_strobe (
        .kind_i  (kind_s),
        .cs_n_i  (cs_n_i),
        .ds_rd_i (ds_rd_i),
        .rw_i    (rw_i),
        .req_o   (req_s)
    );

    hbi_ack_timer #(.ACK_DLY(ACK_DLY)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .active_i (req_s.active),
        .fire_o   (fire_s),
        .ack_o    (ack_o)
    );

    hbi_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .STREAM_W (STREAM_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (addr_s),
        .active_i    (req_s.active),
        .read_i      (req_s.read),
        .fire_i      (fire_s),
        .wdata_i     (dat_i),
        .align_i     (align_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_sel_o   (mem_sel_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .rdata_o     (rdata_s),
        .mode_o      (mode_reg_o),
        .offs_o      (offset_reg_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            dat_q <= '0;
        else if (fire_s && req_s.read)
            dat_q <= rdata_s;
    end

    assign dat_o    = dat_q;
    assign dat_oe_o = ack_o && req_s.read;

endmodule

// File: rtl/host_bus_if_chk.sv
module host_bus_if_chk
    import host_bus_pkg::*;
#(
    parameter int OFF_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             act,
    input logic             ack,
    input logic             mem_we,
    input logic             mem_sel,
    input logic             mem_req,
    input logic [OFF_W-1:0] mem_off,
    input logic [1:0]       rate,
    input logic             im,
    input logic             as_in,
    input logic [1:0]       kind
);
    logic as_seen;

    always_ff @(posedge clk) begin
        if (rst) as_seen <= 1'b0;
        else     as_seen <= as_in;
    end

    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> ($past(act, 1) && $past(act, 2))); // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !act |=> !ack); // R4
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4
    AST_NO_DM_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !mem_sel); // R8
    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (int'(mem_off) < loc_count(rate))); // R6
    AST_TIMING_STICKY: assert property (@(posedge clk) disable iff (rst)
        (im && !(as_in && !as_seen)) |=> ($stable(kind) || !im)); // R2

endmodule

bind host_bus_if host_bus_if_chk #(.OFF_W(ADDR_W - 1)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .act     (req_s.active),
    .ack     (ack_o),
    .mem_we  (mem_we_o),
    .mem_sel (mem_sel_o),
    .mem_req (mem_req_o),
    .mem_off (mem_addr_o[ADDR_W-2:0]),
    .rate    (mode_reg_o[1:0]),
    .im      (im_i),
    .as_in   (as_i),
    .kind    (kind_s)
);

// File: tb/host_bus_if_tb_top.sv
module host_bus_if_tb_top;
    import host_bus_pkg::*;

    localparam int DW  = 16;
    localparam int AW  = 8;
    localparam int SW  = 5;
    localparam int MAW = SW + AW - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          im_i, cs_n_i, as_i, ds_rd_i, rw_i;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] dat_i, dat_o, mem_wdata_o, mem_rdata_i, mode_reg_o, offset_reg_o;
    logic          dat_oe_o, ack_o, mem_req_o, mem_we_o, mem_sel_o;
    logic [MAW-1:0] mem_addr_o;
    logic [DW-1:0] align_i = 16'hC0DE;

    logic [DW-1:0] conn_mem [0:(1<<MAW)-1];
    logic [DW-1:0] exp_conn [0:(1<<MAW)-1];
    logic [DW-1:0] m_mode, m_offs;
    logic [5:0]    m_ctrl;

    int n_chk = 0, n_fail = 0;
    int we_cnt = 0, bad_dm_we = 0, bad_range = 0;
    bit done = 0;

    always #10 clk = ~clk;

    host_bus_if dut_i (
        .clk(clk), .rst(rst), .im_i(im_i), .cs_n_i(cs_n_i), .as_i(as_i),
        .ds_rd_i(ds_rd_i), .rw_i(rw_i), .addr_i(addr_i), .dat_i(dat_i),
        .dat_o(dat_o), .dat_oe_o(dat_oe_o), .ack_o(ack_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_sel_o(mem_sel_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .align_i(align_i),
        .mode_reg_o(mode_reg_o), .offset_reg_o(offset_reg_o)
    );

    function automatic logic [DW-1:0] dm_pat(input logic [MAW-1:0] a);
        return {a[3:0], a} ^ 16'h5A3C;
    endfunction

    assign mem_rdata_i = mem_sel_o ? dm_pat(mem_addr_o) : conn_mem[mem_addr_o];

    always @(posedge clk) begin
        if (mem_we_o) begin
            conn_mem[mem_addr_o] <= mem_wdata_o;
            we_cnt <= we_cnt + 1;
            if (mem_sel_o) bad_dm_we <= bad_dm_we + 1;
        end
        if (!rst && mem_req_o && int'(mem_addr_o[6:0]) >= loc_count(mode_reg_o[1:0]))
            bad_range <= bad_range + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [AW-1:0] a);
        return int'(a[6:0]) < loc_count(m_mode[1:0]);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (!a[7]) begin
            case (a[6:0])
                7'd0: return m_mode;
                7'd1: return {10'd0, m_ctrl};
                7'd2: return align_i;
                7'd3: return m_offs;
                default: return '0;
            endcase
        end
        if (!in_win(a)) return '0;
        if (m_ctrl[5]) return dm_pat({m_ctrl[4:0], a[6:0]});
        return exp_conn[{m_ctrl[4:0], a[6:0]}];
    endfunction

    function automatic string tag_of(input int kind, input logic [AW-1:0] a);
        string k = (kind == 0) ? "R1" : "R2,R3";
        string s;
        if (!a[7]) s = (a[6:0] == 7'd2) ? "R8" : "R5";
        else if (!in_win(a)) s = "R6";
        else if (m_ctrl[5]) s = "R8";
        else s = "R7";
        return {k, "/", s};
    endfunction

    // kind: 0 non-multiplexed, 1 timing A, 2 timing B
    task automatic access(input int kind, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int hold,
                          output logic [DW-1:0] rdv);
        if (kind == 0) begin
            im_i = 1'b0; addr_i = a;
        end else begin
            im_i = 1'b1; as_i = 1'b1; dat_i = {8'h00, a};
            ds_rd_i = (kind == 2); rw_i = 1'b1;
            @(negedge clk);
            as_i = 1'b0;
            addr_i = ~a;
        end
        dat_i = wd; cs_n_i = 1'b0;
        case (kind)
            0:       begin ds_rd_i = 1'b0; rw_i = rd; end
            1:       begin ds_rd_i = 1'b1; rw_i = rd; end
            default: begin if (rd) ds_rd_i = 1'b0; else rw_i = 1'b0; end
        endcase
        @(negedge clk);
        check(ack_o == 1'b0, "R4", "ack before second edge", ack_o, 0);
        @(negedge clk);
        check(ack_o == 1'b1, "R4", "ack on second edge", ack_o, 1);
        check(dat_oe_o == rd, "R10", "drive enable with ack", dat_oe_o, rd);
        rdv = dat_o;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(ack_o == 1'b1, "R4", "ack held", ack_o, 1);
        end
        case (kind)
            1:       ds_rd_i = 1'b0;
            default: begin ds_rd_i = 1'b1; rw_i = 1'b1; end
        endcase
        @(negedge clk);
        check(ack_o == 1'b0, "R4", "ack released", ack_o, 0);
        check(dat_oe_o == 1'b0, "R10", "drive enable released", dat_oe_o, 0);
        cs_n_i = 1'b1;
    endtask

    task automatic do_write(input int kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int hold);
        logic [DW-1:0] dummy;
        int w0 = we_cnt;
        int exp_we = (a[7] && in_win(a) && !m_ctrl[5]) ? 1 : 0;
        string t = tag_of(kind, a);
        access(kind, 1'b0, a, d, hold, dummy);
        check(we_cnt - w0 == exp_we, t, "memory write pulses", we_cnt - w0, exp_we);
        if (!a[7]) begin
            case (a[6:0])
                7'd0: m_mode = d;
                7'd1: m_ctrl = d[5:0];
                7'd3: m_offs = d;
                default: ;
            endcase
        end else if (exp_we == 1) begin
            exp_conn[{m_ctrl[4:0], a[6:0]}] = d;
        end
    endtask

    task automatic do_read(input int kind, input logic [AW-1:0] a, input int hold);
        logic [DW-1:0] v;
        logic [DW-1:0] e = exp_read(a);
        string t = tag_of(kind, a);
        access(kind, 1'b1, a, DW'($urandom), hold, v);
        check(v == e, {t, ",R10"}, $sformatf("read addr %0h", a), v, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240));
        for (int i = 0; i < (1 << MAW); i++) begin
            conn_mem[i] = '0; exp_conn[i] = '0;
        end
        m_mode = '0; m_ctrl = '0; m_offs = '0;
        rst = 1'b1; im_i = 1'b0; cs_n_i = 1'b1; as_i = 1'b0;
        ds_rd_i = 1'b1; rw_i = 1'b1; addr_i = '0; dat_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(ack_o == 0, "R9", "ack after reset", ack_o, 0);
        check(dat_oe_o == 0, "R9", "drive enable after reset", dat_oe_o, 0);
        check(mode_reg_o == 0, "R9", "mode after reset", mode_reg_o, 0);
        check(offset_reg_o == 0, "R9", "offset after reset", offset_reg_o, 0);
        check(mem_req_o == 0, "R9", "request after reset", mem_req_o, 0);
        do_read(0, 8'h01, 0);

        // Directed: 128-location window, stream 3, connection memory
        do_write(0, 8'h00, 16'h0002, 0);
        check(mode_reg_o == 16'h0002, "R5", "mode register port", mode_reg_o, 2);
        do_write(1, 8'h01, 16'hFFC3, 0);
        do_read(2, 8'h01, 0);
        do_write(2, 8'h80 | 8'd100, 16'hBEEF, 3);
        check(conn_mem[{5'd3, 7'd100}] == 16'hBEEF, "R7", "memory address mapping",
              conn_mem[{5'd3, 7'd100}], 16'hBEEF);
        do_read(0, 8'h80 | 8'd100, 0);
        do_read(1, 8'h80 | 8'd100, 2);
        do_read(2, 8'h80 | 8'd100, 0);

        // Window sizes
        do_write(0, 8'h00, 16'h0000, 0);
        do_write(0, 8'h80 | 8'd31, 16'h1111, 0);
        do_write(1, 8'h80 | 8'd32, 16'h2222, 0);
        do_read(0, 8'h80 | 8'd31, 0);
        do_read(2, 8'h80 | 8'd32, 0);
        do_write(0, 8'h00, 16'h0001, 0);
        do_write(2, 8'h80 | 8'd63, 16'h3333, 0);
        do_write(2, 8'h80 | 8'd64, 16'h4444, 0);
        do_read(1, 8'h80 | 8'd63, 0);
        do_read(1, 8'h80 | 8'd64, 0);

        // Data memory and alignment value are read-only
        do_write(0, 8'h01, 16'h0027, 0);
        check(mem_sel_o == 1'b1, "R7", "memory select port", mem_sel_o, 1);
        do_read(0, 8'h85, 0);
        do_write(1, 8'h85, 16'h9999, 0);
        do_read(2, 8'h85, 0);
        do_write(0, 8'h02, 16'h1234, 0);
        do_read(1, 8'h02, 0);

        // Offset register and unused register offsets
        do_write(2, 8'h03, 16'h55AA, 0);
        check(offset_reg_o == 16'h55AA, "R5", "offset register port", offset_reg_o, 16'h55AA);
        do_write(0, 8'h10, 16'hFFFF, 0);
        do_read(0, 8'h10, 0);

        // Chip select withdrawn while strobe remains
        im_i = 1'b0; addr_i = 8'h00; cs_n_i = 1'b0; ds_rd_i = 1'b0; rw_i = 1'b1;
        repeat (2) @(negedge clk);
        check(ack_o == 1'b1, "R4", "ack before deselect", ack_o, 1);
        cs_n_i = 1'b1;
        @(negedge clk);
        check(ack_o == 1'b0, "R4", "ack after deselect", ack_o, 0);
        ds_rd_i = 1'b1;
        @(negedge clk);

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int kind = int'($urandom % 3);
            int hold = int'($urandom % 3);
            logic [AW-1:0] a;
            if ($urandom % 2) a = {1'b0, 7'($urandom % 6)};
            else a = {1'b1, 7'($urandom)};
            if ($urandom % 2) do_read(kind, a, hold);
            else do_write(kind, a, DW'($urandom), hold);
        end

        check(bad_dm_we == 0, "R8", "data memory write pulses", bad_dm_we, 0);
        check(bad_range == 0, "R6", "requests outside window", bad_range, 0);
        finish_run();
    end

endmodule